// File: doc/BRIEF.md
# SLC-96 Receive Framing-Bit Extractor

This block sits behind a T1 receive framer that has already found D4 superframe alignment. For every frame it is handed the single framing bit, a one-cycle valid strobe and a flag saying whether the frame is a terminal-framing (Ft) frame or a signalling-framing (Fs) frame. Six D4 superframes form one 72-frame SLC-96 multiframe. In each multiframe, the 36 Ft bits keep their normal role. The 36 Fs slots are split into a fixed 12-bit alignment word followed by 24 message bits.

The extractor first searches the Fs positions for the alignment word. It declares alignment once the word reappears at the same position one multiframe later. While aligned, it gathers the 24 message bits into a staging register. At the end of every multiframe whose alignment word was correct, it copies them in one cycle into three 8-bit holding registers. Each copy sets a sticky update flag and fires a one-clock interrupt. The host then has one multiframe period (9 ms on a real line) to read the registers before they can change. The extractor runs only when it is enabled, D4 mode is selected and cross-coupled Ft/Fs synchronisation is selected.

Top module: `slc96_rx_extractor`

## Requirements
- R1: After reset, `upd_flag`, `upd_irq` and `mf_aligned` are 0 and every holding register reads 0.
- R2: Only frames with `frm_is_ft`=0 are used, and Ft-frame bits have no effect. Fs slot k (k = 0..35) is frame 2k+1 of the 72-frame multiframe. Slots 0..11 carry the alignment word MSB-first, with default 12'b000111000111. Slots 12..35 carry the message, whose first-arriving bit is message bit 23.
- R3: While not aligned, the block hunts for the alignment word in the Fs bit stream. `mf_aligned` rises when the word is seen again at the same position one multiframe (72 frames) later, and stays 0 after the first sighting alone.
- R4: While aligned, the message is copied to the holding registers on the last Fs slot of each multiframe whose alignment word matched. `rd_sel`=0 reads message bits 23..16, 1 reads bits 15..8, 2 reads bits 7..0, and 3 reads 0.
- R5: In a multiframe whose alignment word mismatches, the holding registers, `upd_flag` and `upd_irq` are left unchanged.
- R6: A single mismatched multiframe keeps `mf_aligned` at 1. Two consecutive mismatched multiframes clear it, and the block hunts again.
- R7: `upd_flag` sets on each load and stays set until `flag_clr` is high at a clock edge. A load in the same cycle as a clear wins.
- R8: `upd_irq` is high for exactly one clock after each load and never otherwise.
- R9: Between loads the holding registers do not change, so a read anywhere within the following multiframe returns the last loaded message.
- R10: If `rx_en`, `d4_sel` or `xcouple_sel` is 0, no load occurs, `mf_aligned` is 0, and alignment restarts from the hunt once all three are 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Extractor enable |
| d4_sel | input | 1 | Receive framer is in D4 framing mode |
| xcouple_sel | input | 1 | Cross-coupled Ft/Fs synchronisation selected |
| frm_vld | input | 1 | One-cycle strobe: a new framing bit is present |
| frm_bit | input | 1 | Framing bit of the current frame |
| frm_is_ft | input | 1 | 1 = Ft frame, 0 = Fs frame |
| flag_clr | input | 1 | Clears the sticky update flag |
| rd_sel | input | 2 | Holding register select for the read port |
| rd_data | output | 8 | Selected holding register |
| upd_flag | output | 1 | Sticky flag: new message loaded |
| upd_irq | output | 1 | One-clock pulse on each load |
| mf_aligned | output | 1 | Multiframe alignment held |

## Verification
The assertions watch the notification and data path on every cycle. The interrupt is a single-cycle pulse that always comes with the flag and only while aligned. The flag rises only on a load and falls after a clear. The read data holds still between loads. Loss of enable or mode always forces the aligned output low. The alignment sequence itself can only be shown by the bench's scenarios. These include hunting and confirmation over two multiframes, tolerance of one corrupted alignment word, loss after two, recovery, and the bit-to-register mapping. The bench scenarios also cover set-over-clear priority and random messages with random frame gaps.

// File: rtl/slc96_pkg.sv
package slc96_pkg;

  localparam int unsigned SLC_PAT_W   = 12;
  localparam int unsigned SLC_MSG_W   = 24;
  localparam int unsigned SLC_REG_W   = 8;
  localparam logic [SLC_PAT_W-1:0] SLC_PATTERN = 12'b000111000111;

  typedef enum logic [1:0] {
    SYNC_HUNT    = 2'd0,
    SYNC_CONFIRM = 2'd1,
    SYNC_LOCK    = 2'd2
  } sync_state_t;

endpackage

// File: rtl/slc96_mf_tracker.sv
module slc96_mf_tracker
  import slc96_pkg::*;
#(
  parameter int unsigned PAT_W      = SLC_PAT_W,
  parameter int unsigned MSG_W      = SLC_MSG_W,
  parameter logic [PAT_W-1:0] PATTERN = SLC_PATTERN,
  parameter int unsigned MISS_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic frm_vld,
  input  logic frm_bit,
  input  logic frm_is_ft,
  output logic msg_stb,
  output logic mf_load,
  output logic locked
);

  localparam int unsigned FS_SLOTS   = PAT_W + MSG_W;
  localparam int unsigned MF_FRAMES  = 2 * FS_SLOTS;
  localparam int unsigned CNT_W      = $clog2(MF_FRAMES);
  localparam int unsigned CHK_FRAME  = 2 * PAT_W - 1;
  localparam int unsigned LAST_FRAME = MF_FRAMES - 1;
  localparam int unsigned MISS_W     = $clog2(MISS_LIMIT + 1);

  sync_state_t         state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [PAT_W-1:0]    win_q, win_d;
  logic [MISS_W-1:0]   miss_q, miss_d;
  logic                mf_ok_q, mf_ok_d;

  logic             any_stb, fs_stb, at_chk, pat_hit;
  logic [PAT_W-1:0] win_next;

  assign any_stb  = active & frm_vld;
  assign fs_stb   = any_stb & ~frm_is_ft;
  assign win_next = {win_q[PAT_W-2:0], frm_bit};
  assign pat_hit  = (win_next == PATTERN);
  assign at_chk   = fs_stb && (cnt_q == CNT_W'(CHK_FRAME));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    win_d   = win_q;
    miss_d  = miss_q;
    mf_ok_d = mf_ok_q;
    if (!active) begin
      state_d = SYNC_HUNT;
      cnt_d   = '0;
      win_d   = '0;
      miss_d  = '0;
      mf_ok_d = 1'b0;
    end else begin
      if (fs_stb) begin
        win_d = win_next;
      end
      if (any_stb) begin
        cnt_d = (cnt_q == CNT_W'(LAST_FRAME)) ? '0 : cnt_q + 1'b1;
      end
      unique case (state_q)
        SYNC_HUNT: begin
          if (fs_stb && pat_hit) begin
            state_d = SYNC_CONFIRM;
            cnt_d   = CNT_W'(CHK_FRAME + 1);
          end
        end
        SYNC_CONFIRM: begin
          if (at_chk) begin
            if (pat_hit) begin
              state_d = SYNC_LOCK;
              mf_ok_d = 1'b1;
              miss_d  = '0;
            end else begin
              state_d = SYNC_HUNT;
            end
          end
        end
        SYNC_LOCK: begin
          if (at_chk) begin
            if (pat_hit) begin
              mf_ok_d = 1'b1;
              miss_d  = '0;
            end else begin
              mf_ok_d = 1'b0;
              if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                state_d = SYNC_HUNT;
                miss_d  = '0;
              end else begin
                miss_d = miss_q + 1'b1;
              end
            end
          end
        end
        default: state_d = SYNC_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SYNC_HUNT;
      cnt_q   <= '0;
      win_q   <= '0;
      miss_q  <= '0;
      mf_ok_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      win_q   <= win_d;
      miss_q  <= miss_d;
      mf_ok_q <= mf_ok_d;
    end
  end

  assign locked  = (state_q == SYNC_LOCK);
  assign msg_stb = locked && fs_stb && (cnt_q > CNT_W'(CHK_FRAME));
  assign mf_load = locked && fs_stb && (cnt_q == CNT_W'(LAST_FRAME)) && mf_ok_q;

endmodule

// File: rtl/slc96_msg_stage.sv
module slc96_msg_stage
  import slc96_pkg::*;
#(
  parameter int unsigned MSG_W  = SLC_MSG_W,
  parameter int unsigned REG_W  = SLC_REG_W,
  parameter int unsigned RSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              load,
  input  logic [RSEL_W-1:0] rd_sel,
  output logic [REG_W-1:0]  rd_data
);

  localparam int unsigned NUM_REGS = MSG_W / REG_W;

  logic [MSG_W-1:0] stage_q, stage_d;
  logic [MSG_W-1:0] hold_q, hold_d;
  logic [MSG_W-1:0] stage_shifted;
  logic [REG_W-1:0] hold_bytes [NUM_REGS];

  assign stage_shifted = {stage_q[MSG_W-2:0], bit_in};

  always_comb begin
    stage_d = stage_q;
    hold_d  = hold_q;
    if (shift_en) begin
      stage_d = stage_shifted;
    end
    if (load) begin
      hold_d = stage_shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      stage_q <= stage_d;
      hold_q  <= hold_d;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bytes
    assign hold_bytes[g] = hold_q[MSG_W-1-g*REG_W -: REG_W];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel == RSEL_W'(i)) begin
        rd_data = hold_bytes[i];
      end
    end
  end

endmodule

// File: rtl/slc96_upd_notify.sv
module slc96_upd_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clr,
  output logic flag,
  output logic irq
);

  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (clr) begin
      flag_d = 1'b0;
    end
    if (load) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      irq  <= load;
    end
  end

endmodule

// File: rtl/slc96_rx_extractor.sv
module slc96_rx_extractor
  import slc96_pkg::*;
#(
  parameter int unsigned PAT_W      = SLC_PAT_W,
  parameter int unsigned MSG_W      = SLC_MSG_W,
  parameter int unsigned REG_W      = SLC_REG_W,
  parameter logic [PAT_W-1:0] PATTERN = SLC_PATTERN,
  parameter int unsigned MISS_LIMIT = 2,
  parameter int unsigned RSEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              d4_sel,
  input  logic              xcouple_sel,
  input  logic              frm_vld,
  input  logic              frm_bit,
  input  logic              frm_is_ft,
  input  logic              flag_clr,
  input  logic [RSEL_W-1:0] rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              upd_flag,
  output logic              upd_irq,
  output logic              mf_aligned
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       active;
  logic       msg_stb;
  logic       mf_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  assign active = rx_en & d4_sel & xcouple_sel;

  slc96_mf_tracker #(
    .PAT_W      (PAT_W),
    .MSG_W      (MSG_W),
    .PATTERN    (PATTERN),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .active    (active),
    .frm_vld   (frm_vld),
    .frm_bit   (frm_bit),
    .frm_is_ft (frm_is_ft),
    .msg_stb   (msg_stb),
    .mf_load   (mf_load),
    .locked    (mf_aligned)
  );

  slc96_msg_stage #(
    .MSG_W  (MSG_W),
    .REG_W  (REG_W),
    .RSEL_W (RSEL_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .shift_en (msg_stb),
    .bit_in   (frm_bit),
    .load     (mf_load),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
  );

  slc96_upd_notify u_notify (
    .clk   (clk),
    .rst_n (core_rst_n),
    .load  (mf_load),
    .clr   (flag_clr),
    .flag  (upd_flag),
    .irq   (upd_irq)
  );

endmodule

// File: rtl/slc96_rx_chk.sv
module slc96_rx_chk #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned RSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              d4_sel,
  input logic              xcouple_sel,
  input logic              flag_clr,
  input logic [RSEL_W-1:0] rd_sel,
  input logic [REG_W-1:0]  rd_data,
  input logic              upd_flag,
  input logic              upd_irq,
  input logic              mf_aligned
);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_irq |=> !upd_irq);

  p_irq_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_irq |-> upd_flag);

  p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_flag) |-> upd_irq);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (upd_irq || !upd_flag));

  p_load_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_irq |-> mf_aligned);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_irq && $stable(rd_sel)) |-> $stable(rd_data));

  p_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && d4_sel && xcouple_sel) |=> (!mf_aligned && !upd_irq));

endmodule

bind slc96_rx_extractor slc96_rx_chk #(
  .REG_W  (REG_W),
  .RSEL_W (RSEL_W)
) u_rx_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .d4_sel      (d4_sel),
  .xcouple_sel (xcouple_sel),
  .flag_clr    (flag_clr),
  .rd_sel      (rd_sel),
  .rd_data     (rd_data),
  .upd_flag    (upd_flag),
  .upd_irq     (upd_irq),
  .mf_aligned  (mf_aligned)
);

// File: tb/slc96_rx_extractor_tb.sv
module slc96_rx_extractor_tb_top;

  localparam logic [11:0] PAT = 12'b000111000111;

  logic       clk;
  logic       rst_n;
  logic       rx_en, d4_sel, xcouple_sel;
  logic       frm_vld, frm_bit, frm_is_ft;
  logic       flag_clr;
  logic [1:0] rd_sel;
  logic [7:0] rd_data;
  logic       upd_flag, upd_irq, mf_aligned;

  int         n_cmp;
  int         n_bad;
  logic [23:0] exp_msg;
  logic        exp_flag;
  bit          prev_bad;

  slc96_rx_extractor dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .d4_sel      (d4_sel),
    .xcouple_sel (xcouple_sel),
    .frm_vld     (frm_vld),
    .frm_bit     (frm_bit),
    .frm_is_ft   (frm_is_ft),
    .flag_clr    (flag_clr),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .upd_flag    (upd_flag),
    .upd_irq     (upd_irq),
    .mf_aligned  (mf_aligned)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [23:0] m, input int idx);
    return m[23-8*idx -: 8];
  endfunction

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1;
      chk({tag, " R2 R4 read"}, 32'(rd_data), (i < 3) ? 32'(exp_byte(exp_msg, i)) : 32'd0);
    end
    rd_sel = 2'd0;
  endtask

  task automatic send_frame(input logic b, input logic ft, input logic clr);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    @(negedge clk);
    frm_vld   = 1'b1;
    frm_bit   = b;
    frm_is_ft = ft;
    flag_clr  = clr;
    @(negedge clk);
    frm_vld   = 1'b0;
    flag_clr  = 1'b0;
  endtask

  task automatic send_mf(input logic [23:0] msg, input bit good, input bit exp_load,
                         input bit clr_last, input string tag);
    for (int f = 0; f < 72; f++) begin
      logic b;
      logic ft;
      int   s;
      ft = (f % 2 == 0);
      s  = f / 2;
      if (ft) begin
        b = 1'($urandom & 1);
      end else if (s < 12) begin
        b = PAT[11-s];
        if (!good && s == 5) b = ~b;
      end else begin
        b = msg[23-(s-12)];
      end
      send_frame(b, ft, clr_last && (f == 71));
      if (f == 50) chk_regs({tag, " window R9"});
    end
    chk({tag, " R8 irq"}, 32'(upd_irq), 32'(exp_load));
    if (exp_load) begin
      exp_msg  = msg;
      exp_flag = 1'b1;
    end
    chk({tag, " R7 flag"}, 32'(upd_flag), 32'(exp_flag));
    chk_regs({tag, " R5"});
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    exp_flag = 1'b0;
    chk("R7 cleared", 32'(upd_flag), 32'd0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] m;
    void'($urandom(32'h51C9_6A0B));
    n_cmp = 0; n_bad = 0;
    exp_msg = '0; exp_flag = 1'b0; prev_bad = 1'b0;
    rst_n = 1'b0; rx_en = 1'b1; d4_sel = 1'b1; xcouple_sel = 1'b1;
    frm_vld = 1'b0; frm_bit = 1'b0; frm_is_ft = 1'b0;
    flag_clr = 1'b0; rd_sel = 2'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 flag", 32'(upd_flag), 32'd0);
    chk("R1 irq", 32'(upd_irq), 32'd0);
    chk("R1 aligned", 32'(mf_aligned), 32'd0);
    chk_regs("R1");

    // R3 hunt, then confirm one multiframe later
    send_mf(24'h5A_C3_81, 1, 0, 0, "mf1");
    chk("R3 not yet aligned", 32'(mf_aligned), 32'd0);
    send_mf(24'hA5_3C_7E, 1, 1, 0, "mf2");
    chk("R3 aligned", 32'(mf_aligned), 32'd1);
    @(negedge clk);
    chk("R8 pulse ended", 32'(upd_irq), 32'd0);
    chk("R7 sticky", 32'(upd_flag), 32'd1);
    clear_flag();
    chk_regs("R9 after clear");

    // R5 R6 one bad word: no load, alignment kept
    send_mf(24'hFF_00_FF, 0, 0, 0, "mf3 bad");
    chk("R6 one miss kept", 32'(mf_aligned), 32'd1);
    send_mf(24'h12_34_56, 1, 1, 0, "mf4");
    send_mf(24'h9E_77_21, 0, 0, 0, "mf5 bad");
    chk("R6 first miss", 32'(mf_aligned), 32'd1);
    send_mf(24'h00_00_00, 0, 0, 0, "mf6 bad");
    chk("R6 two misses drop", 32'(mf_aligned), 32'd0);

    // R3 recovery
    send_mf(24'hC0_FF_EE, 1, 0, 0, "mf7 hunt");
    chk("R3 reconfirm pending", 32'(mf_aligned), 32'd0);
    send_mf(24'hBE_EF_01, 1, 1, 0, "mf8");

    // R7 set wins over simultaneous clear
    clear_flag();
    send_mf(24'h0F_1E_2D, 1, 1, 1, "mf9 set-wins R7");

    // R10 disabled: no load, alignment lost
    rx_en = 1'b0;
    send_mf(24'h33_44_55, 1, 0, 0, "mf10 disabled R10");
    chk("R10 disabled aligned", 32'(mf_aligned), 32'd0);
    rx_en = 1'b1;
    send_mf(24'h66_77_88, 1, 0, 0, "mf11 hunt");
    send_mf(24'h99_AA_BB, 1, 1, 0, "mf12");

    d4_sel = 1'b0;
    send_frame(1'b1, 1'b0, 1'b0);
    chk("R10 d4 off", 32'(mf_aligned), 32'd0);
    d4_sel = 1'b1;
    send_mf(24'h01_02_03, 1, 0, 0, "mf13 hunt");
    send_mf(24'h04_05_06, 1, 1, 0, "mf14");
    xcouple_sel = 1'b0;
    send_frame(1'b0, 1'b0, 1'b0);
    chk("R10 xcouple off", 32'(mf_aligned), 32'd0);
    xcouple_sel = 1'b1;
    send_mf(24'h07_08_09, 1, 0, 0, "mf15 hunt");
    send_mf(24'h0A_0B_0C, 1, 1, 0, "mf16");

    // random multiframes, never two bad in a row
    for (int k = 0; k < 10; k++) begin
      bit good;
      m = 24'($urandom);
      good = prev_bad ? 1'b1 : (($urandom % 4) != 0);
      send_mf(m, good, good, 0, "rand R4");
      chk("R6 random aligned", 32'(mf_aligned), 32'd1);
      prev_bad = !good;
      if (($urandom % 3) == 0) clear_flag();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule